// File: doc/BRIEF.md
# UART Register Access Slave

This block is the protocol engine behind a byte-wide 8N1 serial receiver and transmitter. The UART sends bytes LSB first at a selectable 19.2 or 38.4 kbaud, and this block does not see the bit level. The host opens each transaction with a command byte and a length byte. The command byte carries a 7-bit register address and a direction flag. A write then takes that many data bytes from the receive stream and puts them into a byte-addressed register file. A read streams that many register bytes out through a ready/valid transmit port.

Each register is `REG_BYTES` bytes wide and is moved most significant byte first. A block access that runs past the last byte of a register continues at the first byte of the next address. The address wraps from 127 to 0. The engine works only while the active-low chip enable is held low. Raising the chip enable returns the engine to waiting for a command byte. If the host leaves too long a gap between bytes it must send, the transaction is dropped.

Top module: `urs_top`

## Requirements
- R1: In a command byte, bits [7:1] give the starting register address (0 to 127) and bit 0 gives the direction: 1 is a read and 0 is a write.
- R2: The byte after the command gives the number N of data bytes. Exactly N bytes are written or sent, and then the engine waits for a new command byte.
- R3: Register bytes are addressed by an offset where 0 is the most significant byte. Every transfer starts at offset 0 of the addressed register and moves to higher offsets, so bytes go most significant first.
- R4: After the byte at offset `REG_BYTES`-1, the transfer continues at offset 0 of the next register address.
- R5: During a block access, the address after 127 is 0.
- R6: A length of 0 ends the transaction at once. A read sends no byte, and the next received byte is taken as a command.
- R7: While `cs_ni` is high, received bytes are ignored, nothing is written and `tx_valid_o` is low. A high pulse on `cs_ni` abandons any open transaction.
- R8: While a length byte or write data byte is expected, a byte that arrives after `GAP_CYC` or more consecutive cycles without a received byte is dropped, and the transaction is abandoned. A byte that arrives after `GAP_CYC`-1 idle cycles is accepted.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, the offered byte and the register location stay unchanged. Each accepted handshake sends exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip enable, active low; high holds the engine idle |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte valid, one cycle per byte |
| tx_data_o | output | 8 | Byte offered to the transmitter |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| reg_addr_o | output | 7 | Register address of the current byte |
| reg_ofs_o | output | OFS_W | Byte offset within the register, 0 = most significant |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | Byte write strobe |
| reg_rdata_i | input | 8 | Read data of the addressed byte, combinational |

## Verification
The hardest case to reach is the exact edge of the gap timeout. That edge lies in the middle of a write, after some bytes have already been stored. The stimulus counts idle cycles one by one. It sends one data byte after `GAP_CYC`-1 idle cycles and the next after exactly `GAP_CYC` idle cycles. A readback then shows which bytes were stored. The same readback method shows that a chip-enable pulse in mid-write, a block crossing of address 127, and zero-length commands do what the requirements say.

// File: rtl/urs_pkg.sv
package urs_pkg;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_LEN = 2'd1,
    ST_WR  = 2'd2,
    ST_RD  = 2'd3
  } urs_state_e;
endpackage

// File: rtl/urs_gap_timer.sv
module urs_gap_timer #(
  parameter int GAP_CYC = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(GAP_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GAP_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || clr_i)   cnt_q <= '0;
    else if (cnt_q != LIMIT)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LIMIT);

  // R8
  gap_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && cnt_q != LIMIT) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R8
  gap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || !run_i) |=> (cnt_q == '0));
endmodule

// File: rtl/urs_addr_walk.sv
module urs_addr_walk #(
  parameter int REG_BYTES = 4,
  parameter int OFS_W     = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [urs_pkg::ADDR_W-1:0] load_addr_i,
  input  logic                       step_i,
  output logic [urs_pkg::ADDR_W-1:0] addr_o,
  output logic [OFS_W-1:0]           ofs_o
);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(REG_BYTES - 1);

  logic [urs_pkg::ADDR_W-1:0] addr_q;
  logic [OFS_W-1:0]           ofs_q;
  logic                       at_last;

  assign at_last = (ofs_q == LAST_OFS);

  generate
    if (REG_BYTES > 1) begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      ofs_q <= '0;
        else if (load_i)  ofs_q <= '0;
        else if (step_i)  ofs_q <= at_last ? '0 : ofs_q + 1'b1;
      end
    end else begin : g_single
      assign ofs_q = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addr_q <= '0;
    else if (load_i)            addr_q <= load_addr_i;
    else if (step_i && at_last) addr_q <= addr_q + 1'b1;  // 127 wraps to 0
  end

  assign addr_o = addr_q;
  assign ofs_o  = ofs_q;

  // R4
  reg_cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && at_last) |=> (ofs_q == '0 && addr_q == $past(addr_q) + 1'b1));

  // R5
  addr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && at_last && addr_q == '1) |=> (addr_q == '0));

  // R3
  load_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ofs_q == '0 && addr_q == $past(load_addr_i)));
endmodule

// File: rtl/urs_top.sv
module urs_top #(
  parameter int REG_BYTES = 4,
  parameter int GAP_CYC   = 100000,
  parameter int OFS_W     = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_valid_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [6:0]       reg_addr_o,
  output logic [OFS_W-1:0] reg_ofs_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_we_o,
  input  logic [7:0]       reg_rdata_i
);
  import urs_pkg::*;

  urs_state_e state_q;
  logic       rd_q;
  logic [7:0] cnt_q;
  logic       gap_exp;
  logic       gap_run;
  logic       byte_ok;
  logic       tx_fire;
  logic       load;
  logic       step;

  assign gap_run = !cs_ni && (state_q == ST_LEN || state_q == ST_WR);
  assign byte_ok = rx_valid_i && !cs_ni && !gap_exp;
  assign tx_fire = (state_q == ST_RD) && !cs_ni && tx_ready_i;
  assign load    = (state_q == ST_CMD) && byte_ok;
  assign step    = ((state_q == ST_WR) && byte_ok) || tx_fire;

  urs_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (gap_run),
    .clr_i     (byte_ok),
    .expired_o (gap_exp)
  );

  urs_addr_walk #(.REG_BYTES(REG_BYTES), .OFS_W(OFS_W)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_addr_i (rx_data_i[7:1]),
    .step_i      (step),
    .addr_o      (reg_addr_o),
    .ofs_o       (reg_ofs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      rd_q    <= 1'b0;
      cnt_q   <= '0;
    end else if (cs_ni) begin
      state_q <= ST_CMD;
    end else begin
      unique case (state_q)
        ST_CMD: if (byte_ok) begin
          rd_q    <= rx_data_i[0];
          state_q <= ST_LEN;
        end
        ST_LEN: begin
          if (gap_exp) state_q <= ST_CMD;
          else if (byte_ok) begin
            cnt_q <= rx_data_i;
            if (rx_data_i == 8'd0) state_q <= ST_CMD;
            else                   state_q <= rd_q ? ST_RD : ST_WR;
          end
        end
        ST_WR: begin
          if (gap_exp) state_q <= ST_CMD;
          else if (byte_ok) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == 8'd1) state_q <= ST_CMD;
          end
        end
        ST_RD: if (tx_fire) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == 8'd1) state_q <= ST_CMD;
        end
        default: state_q <= ST_CMD;
      endcase
    end
  end

  assign reg_we_o    = (state_q == ST_WR) && byte_ok;
  assign reg_wdata_o = rx_data_i;
  assign tx_valid_o  = (state_q == ST_RD) && !cs_ni;
  assign tx_data_o   = reg_rdata_i;

  // R2
  len_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR || state_q == ST_RD) |-> (cnt_q != 8'd0));

  // R6
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEN && byte_ok && rx_data_i == 8'd0) |=> (state_q == ST_CMD && !tx_valid_o));

  // R7
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (state_q == ST_CMD));

  // R9
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=>
      (cs_ni || (tx_valid_o && $stable(reg_addr_o) && $stable(reg_ofs_o))));

  // R8
  gap_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_exp && !cs_ni) |=> (state_q == ST_CMD));

  // R1
  dir_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_valid_o, reg_we_o}));
endmodule

// File: tb/urs_top_test.sv
module urs_top_test;
  localparam int RB    = 4;
  localparam int GAP   = 20;
  localparam int OFS_W = 2;
  localparam int NB    = 128 * RB;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cs_ni = 1'b0;
  logic [7:0]       rx_data = '0;
  logic             rx_valid = 1'b0;
  logic [7:0]       tx_data;
  logic             tx_valid;
  logic             tx_ready = 1'b1;
  logic [6:0]       reg_addr;
  logic [OFS_W-1:0] reg_ofs;
  logic [7:0]       reg_wdata;
  logic             reg_we;
  logic [7:0]       reg_rdata;

  logic [7:0] rf  [NB];
  logic [7:0] exp_b [NB];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  urs_top #(.REG_BYTES(RB), .GAP_CYC(GAP), .OFS_W(OFS_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .reg_addr_o(reg_addr), .reg_ofs_o(reg_ofs),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  assign reg_rdata = rf[{reg_addr, reg_ofs}];
  always @(posedge clk) if (reg_we) rf[{reg_addr, reg_ofs}] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a, input int i, input int s);
    return 8'((a * 7 + i * 13 + s) & 8'hFF);
  endfunction

  // write: cmd bit0=0, bytes go linearly from a*RB, wrapping at NB (R3, R4, R5)
  task automatic wr(input int a, input int len, input int seed);
    send_byte({7'(a), 1'b0});
    send_byte(8'(len));
    for (int i = 0; i < len; i++) begin
      send_byte(pat(a, i, seed));
      exp_b[(a * RB + i) % NB] = pat(a, i, seed);
    end
  endtask

  task automatic rd(input int a, input int len, input string req);
    send_byte({7'(a), 1'b1});
    send_byte(8'(len));
    for (int i = 0; i < len; i++) begin
      chk(tx_valid === 1'b1, req, int'(tx_valid), 1);
      chk(tx_data === exp_b[(a * RB + i) % NB], req, int'(tx_data),
          int'(exp_b[(a * RB + i) % NB]));
      @(negedge clk);
    end
    chk(tx_valid === 1'b0, {req, " R2 end"}, int'(tx_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      rf[i] = '0;
      exp_b[i] = '0;
    end
    idle(3);
    chk(tx_valid === 1'b0 && reg_we === 1'b0, "reset", int'({tx_valid, reg_we}), 0);
    rst_ni = 1'b1;
    idle(2);

    // R1 R3: every register written then read back
    for (int a = 0; a < 128; a++) wr(a, RB, 1);
    for (int a = 0; a < 128; a++) rd(a, RB, "R1");

    // R3: partial read yields the top bytes only, R2 stops after N
    rd(5, 3, "R3");

    // R4 R5: block write across 126, 127, 0
    wr(126, 3 * RB, 40);
    rd(127, 2 * RB, "R5");
    rd(126, 3 * RB, "R4");
    wr(60, 10, 77);
    rd(60, 12, "R4");

    // R6: zero-length read then zero-length write; next byte is a command
    send_byte(8'h0B);
    send_byte(8'h00);
    for (int i = 0; i < 4; i++) begin
      chk(tx_valid === 1'b0, "R6", int'(tx_valid), 0);
      @(negedge clk);
    end
    send_byte(8'h14);
    send_byte(8'h00);
    rd(9, 2, "R6");

    // R7: chip enable pulse mid-write abandons it; bytes while high ignored
    send_byte({7'd20, 1'b0});
    send_byte(8'd4);
    send_byte(8'hA1);
    exp_b[20 * RB] = 8'hA1;
    cs_ni = 1'b1;
    send_byte(8'hB2);
    send_byte({7'd21, 1'b0});
    send_byte(8'd1);
    send_byte(8'hC3);
    chk(tx_valid === 1'b0 && reg_we === 1'b0, "R7", int'({tx_valid, reg_we}), 0);
    cs_ni = 1'b0;
    idle(1);
    rd(20, 2 * RB, "R7");
    // R7: tx_valid drops while chip enable high during a read
    send_byte({7'd30, 1'b1});
    send_byte(8'd4);
    cs_ni = 1'b1;
    @(negedge clk);
    chk(tx_valid === 1'b0, "R7", int'(tx_valid), 0);
    cs_ni = 1'b0;
    idle(1);
    rd(30, RB, "R7");

    // R8: gap GAP-1 accepted, gap GAP aborts
    send_byte({7'd40, 1'b0});
    send_byte(8'd4);
    send_byte(8'h5A);
    exp_b[40 * RB] = 8'h5A;
    idle(GAP - 1);
    send_byte(8'h6B);
    exp_b[40 * RB + 1] = 8'h6B;
    idle(GAP);
    send_byte(8'h7C);
    idle(1);
    rd(40, RB, "R8");

    // R9: backpressure holds the byte
    send_byte({7'd3, 1'b1});
    send_byte(8'd2);
    tx_ready = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk(tx_valid === 1'b1 && tx_data === exp_b[3 * RB], "R9", int'(tx_data),
          int'(exp_b[3 * RB]));
      @(negedge clk);
    end
    tx_ready = 1'b1;
    for (int i = 0; i < 2; i++) begin
      chk(tx_data === exp_b[3 * RB + i], "R9", int'(tx_data), int'(exp_b[3 * RB + i]));
      @(negedge clk);
    end
    chk(tx_valid === 1'b0, "R9", int'(tx_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule